// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, one destination address at a time, whether a received Ethernet frame is kept. A host-side loader programs it with a setup frame that arrives as a stream of 32-bit words. Each setup frame picks one of two table formats. In exact mode the table holds sixteen full addresses. In hash mode it holds a 512-bin multicast hash table plus one exact station address.

On the receive side a 48-bit destination address is presented with a valid strobe. One clock later the block reports accept or reject and a reason code. Two control inputs override the table. The promiscuous input accepts everything. The all-multicast input accepts every group address. The hash bin index is taken from a combinational CRC-32 over the six address bytes.

Top module: `rx_addr_filter`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high. `res_accept` and `res_reason` are 0 whenever `res_valid` is 0.
- R2: In exact mode the 48 table words form 16 entries. Entry k is made of words 3k, 3k+1 and 3k+2, which hold address bits [15:0], [31:16] and [47:32] respectively. Any entry equal to `lk_addr` gives accept with reason 1.
- R3: Address byte n is `lk_addr[8n+7:8n]`, and byte 0 is the first byte on the wire. The group (multicast) bit is `lk_addr[0]`.
- R4: In hash mode, with the group bit set, the bin h is bits [8:0] of a CRC-32. The CRC uses the reflected polynomial 0xEDB88320 and an all-ones preset, with no final inversion. It consumes `lk_addr[0]` first up to `lk_addr[47]`. If bit h%16 of table word h/16 is set, the frame is accepted with reason 2.
- R5: In hash mode, words 39, 40 and 41 hold the station address in the R2 layout. An exact station match gives reason 1. An address with the group bit clear never hits the hash table.
- R6: When `promisc` is high, every lookup is accepted with reason 3, whatever the other inputs are.
- R7: When `promisc` is low and `all_multi` is high, every lookup with the group bit set is accepted with reason 4. This takes priority over table hits.
- R8: A `ld_start` pulse latches `ld_hash` (1 selects hash mode, 0 selects exact mode) and clears every table word. The next 48 `ld_valid` words fill words 0..47 in order. Only `ld_word[15:0]` is stored. Words offered after the 48th are ignored.
- R9: From reset until the first complete load, and from `ld_start` until the 48th word is written, table matches are suppressed. The `promisc` and `all_multi` inputs still apply during these periods.
- R10: A lookup that meets none of the above is rejected, with `res_accept` 0 and reason 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 1 | Begin a setup-frame load |
| ld_hash | input | 1 | Table format for this load, 1 = hash |
| ld_valid | input | 1 | Setup word strobe |
| ld_word | input | 32 | Setup word, low half stored |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| promisc | input | 1 | Accept every frame |
| all_multi | input | 1 | Accept every group address |
| res_valid | output | 1 | Lookup result strobe |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 3 | 0 none, 1 exact, 2 hash, 3 promiscuous, 4 all-multicast |

## Verification
The bench fills the last exact slot, so a design whose entry indexing stops short would reject that address. It also sets the hash bin of a unicast address, which catches a design that applies the hash table without testing the group bit. It looks up the previous table's address both during a reload and after it. A design that skips the clear, or that matches on a half-written table, would accept that address. It also combines promiscuous with all-multicast on a group address and checks that promiscuous wins, and it compares CRC-derived bins, including the broadcast bin, with its own serial CRC.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_EXACT   = 3'd1,
    RSN_HASH    = 3'd2,
    RSN_PROMISC = 3'd3,
    RSN_ALLMC   = 3'd4
  } reason_e;

  // Reflected CRC-32, all-ones preset, no final inversion; bit 0 of the
  // address enters first (byte 0 least significant bit first).
  function automatic logic [31:0] addr_crc(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB8_8320;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/afilt_crc.sv
module afilt_crc #(
  parameter int HASH_BITS = 9
) (
  input  logic [47:0]          addr,
  output logic [HASH_BITS-1:0] bin
);
  import afilt_pkg::*;

  logic [31:0] crc_full;

  always_comb begin
    crc_full = addr_crc(addr);
    bin      = crc_full[HASH_BITS-1:0];
  end
endmodule

// File: rtl/afilt_table.sv
module afilt_table #(
  parameter int N_ENTRIES = 16,
  localparam int WORDS    = N_ENTRIES * 3,
  localparam int CW       = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_start,
  input  logic                   ld_hash,
  input  logic                   ld_valid,
  input  logic [15:0]            ld_half,
  output logic [WORDS-1:0][15:0] tbl,
  output logic                   tbl_hash,
  output logic                   tbl_busy,
  output logic                   tbl_ready
);
  logic [CW-1:0] cnt;
  logic          wr_go;
  logic          last_wr;

  assign wr_go   = ld_valid && tbl_busy && !ld_start;
  assign last_wr = wr_go && (cnt == CW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      tbl_busy  <= 1'b0;
      tbl_ready <= 1'b0;
      tbl_hash  <= 1'b0;
    end else if (ld_start) begin
      cnt       <= '0;
      tbl_busy  <= 1'b1;
      tbl_ready <= 1'b0;
      tbl_hash  <= ld_hash;
    end else if (last_wr) begin
      cnt       <= '0;
      tbl_busy  <= 1'b0;
      tbl_ready <= 1'b1;
    end else if (wr_go) begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n || ld_start)                tbl[i] <= '0;
      else if (wr_go && cnt == CW'(i))       tbl[i] <= ld_half;
    end
  end
endmodule

// File: rtl/afilt_match.sv
module afilt_match #(
  parameter int N_ENTRIES    = 16,
  parameter int HASH_BITS    = 9,
  parameter int STATION_WORD = 39,
  localparam int WORDS       = N_ENTRIES * 3
) (
  input  logic [WORDS-1:0][15:0] tbl,
  input  logic                   tbl_hash,
  input  logic                   tbl_ready,
  input  logic [47:0]            addr,
  input  logic [HASH_BITS-1:0]   bin,
  output logic                   exact_hit,
  output logic                   hash_hit
);
  logic [N_ENTRIES-1:0] ent_hit;
  logic                 station_hit;
  logic [15:0]          bin_word;

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_ent
    assign ent_hit[k] = ({tbl[3*k+2], tbl[3*k+1], tbl[3*k]} == addr);
  end

  assign station_hit = ({tbl[STATION_WORD+2], tbl[STATION_WORD+1],
                         tbl[STATION_WORD]} == addr);
  assign bin_word    = tbl[bin[HASH_BITS-1:4]];

  always_comb begin
    exact_hit = 1'b0;
    hash_hit  = 1'b0;
    if (tbl_ready) begin
      if (tbl_hash) begin
        exact_hit = station_hit;
        hash_hit  = addr[0] && bin_word[bin[3:0]];
      end else begin
        exact_hit = |ent_hit;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int N_ENTRIES    = 16,
  parameter int HASH_BITS    = 9,
  parameter int STATION_WORD = 39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_start,
  input  logic        ld_hash,
  input  logic        ld_valid,
  input  logic [31:0] ld_word,
  input  logic        lk_valid,
  input  logic [47:0] lk_addr,
  input  logic        promisc,
  input  logic        all_multi,
  output logic        res_valid,
  output logic        res_accept,
  output logic [2:0]  res_reason
);
  import afilt_pkg::*;

  localparam int WORDS = N_ENTRIES * 3;

  logic [WORDS-1:0][15:0] tbl;
  logic                   tbl_hash;
  logic                   tbl_busy;
  logic                   tbl_ready;
  logic [HASH_BITS-1:0]   lk_bin;
  logic                   ev_exact;
  logic                   ev_hash;
  reason_e                pick;

  afilt_crc #(.HASH_BITS(HASH_BITS)) u_crc (
    .addr (lk_addr),
    .bin  (lk_bin)
  );

  afilt_table #(.N_ENTRIES(N_ENTRIES)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_start  (ld_start),
    .ld_hash   (ld_hash),
    .ld_valid  (ld_valid),
    .ld_half   (ld_word[15:0]),
    .tbl       (tbl),
    .tbl_hash  (tbl_hash),
    .tbl_busy  (tbl_busy),
    .tbl_ready (tbl_ready)
  );

  afilt_match #(
    .N_ENTRIES    (N_ENTRIES),
    .HASH_BITS    (HASH_BITS),
    .STATION_WORD (STATION_WORD)
  ) u_match (
    .tbl       (tbl),
    .tbl_hash  (tbl_hash),
    .tbl_ready (tbl_ready),
    .addr      (lk_addr),
    .bin       (lk_bin),
    .exact_hit (ev_exact),
    .hash_hit  (ev_hash)
  );

  always_comb begin
    if (promisc)                    pick = RSN_PROMISC;
    else if (all_multi && lk_addr[0]) pick = RSN_ALLMC;
    else if (ev_exact)              pick = RSN_EXACT;
    else if (ev_hash)               pick = RSN_HASH;
    else                            pick = RSN_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_reason <= RSN_NONE;
    end else begin
      res_valid  <= lk_valid;
      res_accept <= lk_valid && (pick != RSN_NONE);
      res_reason <= lk_valid ? pick : RSN_NONE;
    end
  end
endmodule

// File: rtl/afilt_chk.sv
module afilt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [47:0] lk_addr,
  input logic        promisc,
  input logic        all_multi,
  input logic        tbl_ready,
  input logic        res_valid,
  input logic        res_accept,
  input logic [2:0]  res_reason
);
  AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid); // R1
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_accept && res_reason == 3'd0)); // R1
  AST_PROMISC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && promisc) |=> (res_accept && res_reason == 3'd3)); // R6
  AST_ALLMC_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !promisc && all_multi && lk_addr[0]) |=> (res_reason == 3'd4)); // R7
  AST_UNICAST_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_addr[0]) |=> (res_reason != 3'd2)); // R5
  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !tbl_ready && !promisc && !all_multi) |=> !res_accept); // R9
  AST_REASON_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_reason <= 3'd4); // R10
endmodule

bind rx_addr_filter afilt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_addr    (lk_addr),
  .promisc    (promisc),
  .all_multi  (all_multi),
  .tbl_ready  (tbl_ready),
  .res_valid  (res_valid),
  .res_accept (res_accept),
  .res_reason (res_reason)
);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_start = 1'b0, ld_hash = 1'b0, ld_valid = 1'b0;
  logic [31:0] ld_word = '0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_addr = '0;
  logic        promisc = 1'b0, all_multi = 1'b0;
  logic        res_valid, res_accept;
  logic [2:0]  res_reason;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] frame [48];

  localparam logic [47:0] STA = 48'h6655_4433_2210;
  localparam logic [47:0] P1  = 48'hAABB_CCDD_EE02;
  localparam logic [47:0] P15 = 48'h7777_8888_9904;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] UNI = 48'h0102_0304_0500;
  localparam logic [47:0] M1  = 48'h1234_5678_9A01;
  localparam logic [47:0] M2  = 48'hCAFE_0000_1103;
  localparam logic [47:0] M3  = 48'h0BAD_F00D_0005;

  always #10 clk = ~clk;

  rx_addr_filter u0 (.*);

  function automatic logic [8:0] ref_bin(input logic [47:0] a);
    logic [31:0] r = '1;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by = a[8*b +: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = r[0] ^ by[j];
        r = {1'b0, r[31:1]};
        if (fb) r = r ^ 32'hEDB88320;
      end
    end
    return r[8:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_entry(int slot_word, logic [47:0] a);
    frame[slot_word]     = a[15:0];
    frame[slot_word + 1] = a[31:16];
    frame[slot_word + 2] = a[47:32];
  endtask

  task automatic set_bin(logic [8:0] h);
    frame[h / 16][h % 16] = 1'b1;
  endtask

  task automatic begin_load(logic hash);
    @(negedge clk); ld_start = 1'b1; ld_hash = hash;
    @(negedge clk); ld_start = 1'b0; ld_hash = 1'b0;
  endtask

  task automatic push_words(int from, int upto);
    for (int i = from; i < upto; i++) begin
      @(negedge clk); ld_valid = 1'b1; ld_word = {16'hA5C3, frame[i]};
    end
    @(negedge clk); ld_valid = 1'b0; ld_word = '0;
  endtask

  task automatic lookup(string req, logic [47:0] a, logic p, logic m,
                        logic exp_acc, logic [2:0] exp_rsn);
    @(negedge clk); lk_valid = 1'b1; lk_addr = a; promisc = p; all_multi = m;
    @(negedge clk);
    check(req, {31'd0, res_valid}, 32'd1);
    check(req, {31'd0, res_accept}, {31'd0, exp_acc});
    check(req, {29'd0, res_reason}, {29'd0, exp_rsn});
    lk_valid = 1'b0; promisc = 1'b0; all_multi = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", {31'd0, res_valid}, 0);
    check("R1 reset accept", {31'd0, res_accept}, 0);
    lookup("R9 unloaded table", STA, 0, 0, 0, 3'd0);
    lookup("R6 promisc unloaded", STA, 1, 0, 1, 3'd3);
    @(negedge clk);
    check("R1 idle after lookup", {31'd0, res_valid}, 0);
  endtask

  task automatic t_exact;
    for (int k = 0; k < 16; k++) put_entry(3 * k, STA);
    put_entry(3, P1);
    put_entry(6, BC);
    put_entry(45, P15);
    begin_load(1'b0);
    push_words(0, 48);
    lookup("R2 station", STA, 0, 0, 1, 3'd1);
    lookup("R2 entry1", P1, 0, 0, 1, 3'd1);
    lookup("R2 last slot", P15, 0, 0, 1, 3'd1);
    lookup("R2 broadcast entry", BC, 0, 0, 1, 3'd1);
    lookup("R10 stray unicast", UNI, 0, 0, 0, 3'd0);
    lookup("R8 zero addr after clear", 48'd0, 0, 0, 0, 3'd0);
    lookup("R3 group miss", M1, 0, 0, 0, 3'd0);
    lookup("R7 allmc group", M1, 0, 1, 1, 3'd4);
    lookup("R7 allmc over exact", BC, 0, 1, 1, 3'd4);
    lookup("R7 allmc unicast miss", UNI, 0, 1, 0, 3'd0);
    lookup("R6 promisc over allmc", M1, 1, 1, 1, 3'd3);
  endtask

  task automatic t_hash;
    logic e2;
    for (int i = 0; i < 48; i++) frame[i] = '0;
    set_bin(ref_bin(M1));
    set_bin(ref_bin(M3));
    set_bin(ref_bin(BC));
    set_bin(ref_bin(UNI));
    put_entry(39, STA);
    begin_load(1'b1);
    push_words(0, 48);
    lookup("R4 hash M1", M1, 0, 0, 1, 3'd2);
    lookup("R4 hash M3", M3, 0, 0, 1, 3'd2);
    lookup("R4 hash broadcast bin", BC, 0, 0, 1, 3'd2);
    e2 = (ref_bin(M2) == ref_bin(M1)) || (ref_bin(M2) == ref_bin(M3)) ||
         (ref_bin(M2) == ref_bin(BC)) || (ref_bin(M2) == ref_bin(UNI));
    lookup("R4 hash unset bin", M2, 0, 0, e2, e2 ? 3'd2 : 3'd0);
    lookup("R5 station in hash", STA, 0, 0, 1, 3'd1);
    lookup("R5 unicast bin set", UNI, 0, 0, 0, 3'd0);
    lookup("R5 other unicast", P1, 0, 0, 0, 3'd0);
  endtask

  task automatic t_reload;
    for (int k = 0; k < 16; k++) put_entry(3 * k, P1);
    begin_load(1'b0);
    push_words(0, 10);
    lookup("R9 during load", STA, 0, 0, 0, 3'd0);
    lookup("R9 during load old hash", M1, 0, 0, 0, 3'd0);
    lookup("R9 promisc during load", STA, 1, 0, 1, 3'd3);
    push_words(10, 47);
    lookup("R9 one word short", P1, 0, 0, 0, 3'd0);
    push_words(47, 48);
    lookup("R8 new table", P1, 0, 0, 1, 3'd1);
    lookup("R8 old station gone", STA, 0, 0, 0, 3'd0);
    frame[0] = 16'h1111;
    push_words(0, 1);
    lookup("R8 extra word ignored", P1, 0, 0, 1, 3'd1);
  endtask

  initial begin
    t_reset();
    t_exact();
    t_hash();
    t_reload();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule